// File: doc/BRIEF.md
# DMA Channel Error Capture Unit

This block records the faults that a multi-channel DMA transfer engine reports. Each fault event carries a channel number and a 4-bit fault code. A fault that belongs to one channel does three things: it sets that channel's sticky bit in a per-channel error array, it overwrites a single last-fault record, and it sends a one-cycle stop request for that channel to the scheduler. It does not touch the done flag or the completion interrupt, and it does not disable the channel. If the same channel faults again, it is recorded and stopped again. Two faults are global configuration faults from the priority comparator: duplicate group priorities and duplicate channel priorities inside a group. These update only the record. They set no channel bit and they request no stop.

The array holds up to 64 channels. Software reads it as a high word (channels 63..32) and a low word (channels 31..0) through a combinational read port, and clears one channel or all channels through a write strobe. A destination bus fault that arrives while a following read sequence is still pending is parked until that read sequence completes. While a fault is parked, the event port applies back-pressure: `err_ready` is low and a presented event is not taken. Otherwise `err_ready` stays high and an event is accepted in any cycle where `err_valid` is high. No event is lost, because the engine holds `err_valid` and the event fields until it sees `err_ready`.

Top module: `dma_err_capture`

## Requirements
- R1: After reset the status word, both error words and `stop_req` read as zero, and `err_ready` is high.
- R2: An accepted fault with code 0..7 (source address, source offset, destination address, destination offset, byte-count, scatter-gather, source bus, destination bus) sets the channel's bit. The bit sits at position chan-32 of the high word (`rd_sel`=1) for channels 32..63, and at position chan of the low word (`rd_sel`=2) for channels 0..31.
- R3: A fault with code 0..7 overwrites the status word (`rd_sel`=0). Bits [13:8] take the channel number. Exactly one type flag is set, at bit 7-code, so code 0 lands at bit 7 and code 7 at bit 0. Bits 15 and 14 are cleared. Codes 10..15 have no effect at all.
- R4: Code 8 (duplicate group priority) sets status bit 15, and code 9 (duplicate channel priority) sets status bit 14. Either one clears all other flags, leaves bits [13:8] unchanged, sets no channel bit and raises no stop request.
- R5: In the cycle after a fault with code 0..7 takes effect, `stop_req` is high for one cycle and `stop_chan` holds that channel.
- R6: A channel that has faulted is not disabled. A repeated fault on it is recorded again and stopped again.
- R7: Status bit 31 is the OR of all 64 channel bits, and status bits 30..16 read zero.
- R8: With `clr_en` high, `clr_all`=0 clears the bit of `clr_chan` and `clr_all`=1 clears every bit. The change, including the fall of bit 31, is visible in the next cycle.
- R9: When a fault and a clear name the same channel in the same cycle, that channel's bit ends set. Other channels are still cleared.
- R10: A code-7 fault accepted with `err_rd_pend`=1 is parked, and `err_ready` is low while it is parked. It takes effect, with record, bit and stop, one cycle after `rd_done` is sampled high. While it is parked nothing is recorded and no other event is taken.
- R11: `rd_sel`=3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_valid | input | 1 | Fault event present |
| err_ready | output | 1 | Fault event can be taken |
| err_chan | input | 6 | Channel of the fault |
| err_type | input | 4 | Fault code |
| err_rd_pend | input | 1 | A following read sequence is still pending |
| rd_done | input | 1 | Pending read sequence completed |
| clr_en | input | 1 | Software clear strobe |
| clr_all | input | 1 | Clear every channel bit |
| clr_chan | input | 6 | Channel to clear |
| rd_sel | input | 2 | Register select: 0 status, 1 high word, 2 low word |
| rd_data | output | 32 | Selected register |
| stop_req | output | 1 | Stop the active channel |
| stop_chan | output | 6 | Channel to stop |

## Verification
A fault event and a software clear can land in the same cycle. There are three cases: both name the same channel, they name different channels, or the clear is a clear-all. The bench drives both strobes on one falling edge. It then compares the two array words against a model in which the set wins over the clear. A parked destination bus fault can also meet `rd_done` while the engine holds a new event at the port. That case is judged by checking that nothing is recorded until one cycle after the release.

// File: rtl/dma_err_pkg.sv
package dma_err_pkg;
  localparam int CHN_W  = 6;
  localparam int MAX_CH = 64;
  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    FC_SRC_ADDR = 4'd0,
    FC_SRC_OFS  = 4'd1,
    FC_DST_ADDR = 4'd2,
    FC_DST_OFS  = 4'd3,
    FC_COUNT    = 4'd4,
    FC_SG_ADDR  = 4'd5,
    FC_SRC_BUS  = 4'd6,
    FC_DST_BUS  = 4'd7,
    FC_GRP_PRIO = 4'd8,
    FC_CH_PRIO  = 4'd9
  } fault_code_e;

  typedef struct packed {
    logic             grp_dup;
    logic             ch_dup;
    logic [CHN_W-1:0] chan;
    logic [7:0]       kind;
  } fault_rec_t;

  function automatic logic is_chan_fault(input logic [CODE_W-1:0] c);
    return c <= FC_DST_BUS;
  endfunction

  function automatic logic is_prio_fault(input logic [CODE_W-1:0] c);
    return (c == FC_GRP_PRIO) || (c == FC_CH_PRIO);
  endfunction
endpackage

// File: rtl/dma_err_hold.sv
module dma_err_hold
  import dma_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHN_W-1:0]  in_chan,
  input  logic [CODE_W-1:0] in_code,
  input  logic              in_rd_pend,
  input  logic              rd_done,
  output logic              cm_valid,
  output logic [CHN_W-1:0]  cm_chan,
  output logic [CODE_W-1:0] cm_code
);
  logic              held_q;
  logic [CHN_W-1:0]  hchan_q;
  logic [CODE_W-1:0] hcode_q;
  logic              take, park, release_now;

  always_comb begin
    in_ready    = !held_q;
    take        = in_valid && in_ready;
    park        = take && (in_code == FC_DST_BUS) && in_rd_pend;
    release_now = held_q && rd_done;
    cm_valid    = (take && !park) || release_now;
    cm_chan     = held_q ? hchan_q : in_chan;
    cm_code     = held_q ? hcode_q : in_code;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q  <= 1'b0;
      hchan_q <= '0;
      hcode_q <= '0;
    end else if (park) begin
      held_q  <= 1'b1;
      hchan_q <= in_chan;
      hcode_q <= in_code;
    end else if (release_now) begin
      held_q  <= 1'b0;
    end
  end

  AST_PARK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !rd_done) |-> !cm_valid); // R10
  AST_PARK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> (held_q && cm_code == FC_DST_BUS)); // R10
endmodule

// File: rtl/dma_err_bits.sv
module dma_err_bits
  import dma_err_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [CHN_W-1:0]  set_chan,
  input  logic              clr_en,
  input  logic              clr_all,
  input  logic [CHN_W-1:0]  clr_chan,
  output logic [MAX_CH-1:0] word
);
  for (genvar i = 0; i < MAX_CH; i++) begin : g_bit
    if (i < NUM_CH) begin : g_live
      logic q;
      logic hit_set, hit_clr;
      always_comb begin
        hit_set = set_en && (set_chan == CHN_W'(i));
        hit_clr = clr_en && (clr_all || (clr_chan == CHN_W'(i)));
      end
      always_ff @(posedge clk) begin
        if (!rst_n)       q <= 1'b0;
        else if (hit_set) q <= 1'b1;
        else if (hit_clr) q <= 1'b0;
      end
      assign word[i] = q;
    end else begin : g_tie
      assign word[i] = 1'b0;
    end
  end

  AST_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> word[$past(set_chan)]); // R2
  AST_CLR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !clr_all && !(set_en && set_chan == clr_chan)) |=> !word[$past(clr_chan)]); // R8
  AST_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && clr_all && !set_en) |=> (word == '0)); // R8
endmodule

// File: rtl/dma_err_status.sv
module dma_err_status
  import dma_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [CHN_W-1:0]  ld_chan,
  input  logic [CODE_W-1:0] ld_code,
  output fault_rec_t        rec
);
  fault_rec_t rec_d;

  always_comb begin
    rec_d = rec;
    if (ld_en) begin
      if (is_chan_fault(ld_code)) begin
        rec_d.grp_dup = 1'b0;
        rec_d.ch_dup  = 1'b0;
        rec_d.chan    = ld_chan;
        rec_d.kind    = 8'h80 >> ld_code[2:0];
      end else if (ld_code == FC_GRP_PRIO) begin
        rec_d.grp_dup = 1'b1;
        rec_d.ch_dup  = 1'b0;
        rec_d.kind    = '0;
      end else if (ld_code == FC_CH_PRIO) begin
        rec_d.grp_dup = 1'b0;
        rec_d.ch_dup  = 1'b1;
        rec_d.kind    = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rec <= '0;
    else        rec <= rec_d;
  end

  AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rec.grp_dup, rec.ch_dup, rec.kind})); // R3
  AST_PRIO_KEEPS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && is_prio_fault(ld_code)) |=> (rec.chan == $past(rec.chan))); // R4
  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en || ld_code > FC_CH_PRIO) |=> (rec == $past(rec))); // R3
endmodule

// File: rtl/dma_err_capture.sv
module dma_err_capture
  import dma_err_pkg::*;
#(
  parameter int NUM_CH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        err_valid,
  output logic        err_ready,
  input  logic [5:0]  err_chan,
  input  logic [3:0]  err_type,
  input  logic        err_rd_pend,
  input  logic        rd_done,
  input  logic        clr_en,
  input  logic        clr_all,
  input  logic [5:0]  clr_chan,
  input  logic [1:0]  rd_sel,
  output logic [31:0] rd_data,
  output logic        stop_req,
  output logic [5:0]  stop_chan
);
  localparam int HALF = MAX_CH / 2;

  logic              cm_valid;
  logic [CHN_W-1:0]  cm_chan;
  logic [CODE_W-1:0] cm_code;
  logic              in_range, set_en, ld_en;
  logic [MAX_CH-1:0] word;
  fault_rec_t        rec;
  logic              any_err;

  dma_err_hold u_hold (
    .clk(clk), .rst_n(rst_n),
    .in_valid(err_valid), .in_ready(err_ready),
    .in_chan(err_chan), .in_code(err_type),
    .in_rd_pend(err_rd_pend), .rd_done(rd_done),
    .cm_valid(cm_valid), .cm_chan(cm_chan), .cm_code(cm_code)
  );

  always_comb begin
    in_range = (int'(cm_chan) < NUM_CH);
    set_en   = cm_valid && is_chan_fault(cm_code) && in_range;
    ld_en    = set_en || (cm_valid && is_prio_fault(cm_code));
  end

  dma_err_bits #(.NUM_CH(NUM_CH)) u_bits (
    .clk(clk), .rst_n(rst_n),
    .set_en(set_en), .set_chan(cm_chan),
    .clr_en(clr_en), .clr_all(clr_all), .clr_chan(clr_chan),
    .word(word)
  );

  dma_err_status u_stat (
    .clk(clk), .rst_n(rst_n),
    .ld_en(ld_en), .ld_chan(cm_chan), .ld_code(cm_code),
    .rec(rec)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stop_req  <= 1'b0;
      stop_chan <= '0;
    end else begin
      stop_req  <= set_en;
      if (set_en) stop_chan <= cm_chan;
    end
  end

  always_comb begin
    any_err = |word;
    case (rd_sel)
      2'd0:    rd_data = {any_err, 15'b0, rec};
      2'd1:    rd_data = word[MAX_CH-1:HALF];
      2'd2:    rd_data = word[HALF-1:0];
      default: rd_data = '0;
    endcase
  end

  AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_req |-> $past(cm_valid && is_chan_fault(cm_code))); // R5
  AST_STOP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_req && !set_en) |=> !stop_req); // R5
  AST_VALID_OR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel == 2'd0) |-> (rd_data[31] == (word != '0))); // R7
endmodule

// File: tb/sim_dma_err_capture.sv
module sim_dma_err_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0, err_rd_pend = 1'b0, rd_done = 1'b0;
  logic        clr_en = 1'b0, clr_all = 1'b0;
  logic [5:0]  err_chan = '0, clr_chan = '0;
  logic [3:0]  err_type = '0;
  logic [1:0]  rd_sel = '0;
  logic        err_ready, stop_req;
  logic [5:0]  stop_chan;
  logic [31:0] rd_data;

  int total = 0, bad = 0;

  logic [63:0] m_bits = '0;
  logic        m_grp = 1'b0, m_chp = 1'b0;
  logic [5:0]  m_chan = '0;
  logic [7:0]  m_kind = '0;

  always #10 clk = ~clk;

  dma_err_capture u0 (
    .clk(clk), .rst_n(rst_n),
    .err_valid(err_valid), .err_ready(err_ready),
    .err_chan(err_chan), .err_type(err_type),
    .err_rd_pend(err_rd_pend), .rd_done(rd_done),
    .clr_en(clr_en), .clr_all(clr_all), .clr_chan(clr_chan),
    .rd_sel(rd_sel), .rd_data(rd_data),
    .stop_req(stop_req), .stop_chan(stop_chan)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reg(input int s);
    case (s)
      0: return {|m_bits, 15'b0, m_grp, m_chp, m_chan, m_kind};
      1: return m_bits[63:32];
      2: return m_bits[31:0];
      default: return 32'h0;
    endcase
  endfunction

  task automatic check_regs(input string req);
    for (int s = 0; s < 4; s++) begin
      rd_sel = s[1:0];
      #1;
      chk(rd_data, exp_reg(s), (s == 3) ? "R11" : req);
    end
  endtask

  task automatic model_rec(input int ch, input int ty);
    if (ty < 8) begin
      m_bits[ch] = 1'b1;
      m_grp = 1'b0; m_chp = 1'b0;
      m_chan = ch[5:0];
      m_kind = 8'h80 >> ty;
    end else if (ty == 8) begin
      m_grp = 1'b1; m_chp = 1'b0; m_kind = '0;
    end else if (ty == 9) begin
      m_grp = 1'b0; m_chp = 1'b1; m_kind = '0;
    end
  endtask

  task automatic send(input int ch, input int ty, input bit pend,
                      input bit c_en, input bit c_all, input int c_ch, input string req);
    bit exp_stop;
    @(negedge clk);
    err_valid = 1'b1; err_chan = ch[5:0]; err_type = ty[3:0]; err_rd_pend = pend;
    clr_en = c_en; clr_all = c_all; clr_chan = c_ch[5:0];
    @(negedge clk);
    err_valid = 1'b0; err_rd_pend = 1'b0; clr_en = 1'b0; clr_all = 1'b0;
    if (c_en) begin
      if (c_all) m_bits = '0;
      else       m_bits[c_ch] = 1'b0;
    end
    if (!(ty == 7 && pend)) model_rec(ch, ty);
    exp_stop = (ty < 8) && !pend;
    chk({31'b0, stop_req}, {31'b0, exp_stop}, req);
    if (exp_stop) chk({26'b0, stop_chan}, ch, "R5");
  endtask

  task automatic clear(input bit c_all, input int c_ch);
    @(negedge clk);
    clr_en = 1'b1; clr_all = c_all; clr_chan = c_ch[5:0];
    @(negedge clk);
    clr_en = 1'b0; clr_all = 1'b0;
    if (c_all) m_bits = '0;
    else       m_bits[c_ch] = 1'b0;
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    check_regs("R1");
    chk({31'b0, stop_req}, 32'd0, "R1");
    chk({31'b0, err_ready}, 32'd1, "R1");

    // R2 R3 R5 R7: every channel, all eight channel fault codes
    for (int ch = 0; ch < 64; ch++) begin
      send(ch, (ch * 3) % 8, 1'b0, 1'b0, 1'b0, 0, "R5");
      check_regs("R2");
    end

    // R6: repeated fault on an already faulted channel
    send(17, 4, 1'b0, 1'b0, 1'b0, 0, "R6");
    check_regs("R6");
    send(17, 4, 1'b0, 1'b0, 1'b0, 0, "R6");
    check_regs("R6");

    // R4: priority faults keep channel field, no stop, no bit
    send(33, 8, 1'b0, 1'b0, 1'b0, 0, "R4");
    check_regs("R4");
    send(2, 9, 1'b0, 1'b0, 1'b0, 0, "R4");
    check_regs("R4");

    // R3: codes 10..15 have no effect
    for (int ty = 10; ty < 16; ty++) begin
      send(ty, ty, 1'b0, 1'b0, 1'b0, 0, "R3");
      check_regs("R3");
    end

    // R8: single clears over every channel, R7 valid bit drops at end
    for (int ch = 0; ch < 64; ch++) begin
      clear(1'b0, 63 - ch);
      check_regs("R8");
    end
    rd_sel = 2'd0; #1;
    chk({31'b0, rd_data[31]}, 32'd0, "R7");

    // R8: clear-all
    send(5, 0, 1'b0, 1'b0, 1'b0, 0, "R5");
    send(50, 6, 1'b0, 1'b0, 1'b0, 0, "R5");
    check_regs("R7");
    clear(1'b1, 0);
    check_regs("R8");

    // R9: fault and clear in the same cycle
    send(3, 1, 1'b0, 1'b0, 1'b0, 0, "R5");
    send(40, 1, 1'b0, 1'b0, 1'b0, 0, "R5");
    send(3, 2, 1'b0, 1'b1, 1'b0, 3, "R9");
    check_regs("R9");
    send(12, 5, 1'b0, 1'b1, 1'b0, 40, "R9");
    check_regs("R9");
    send(20, 0, 1'b0, 1'b1, 1'b1, 0, "R9");
    check_regs("R9");

    // R10: destination bus fault parked behind a pending read
    send(45, 7, 1'b1, 1'b0, 1'b0, 0, "R10");
    chk({31'b0, err_ready}, 32'd0, "R10");
    check_regs("R10");
    @(negedge clk);
    err_valid = 1'b1; err_chan = 6'd9; err_type = 4'd0;
    @(negedge clk);
    err_valid = 1'b0;
    chk({31'b0, stop_req}, 32'd0, "R10");
    check_regs("R10");
    rd_done = 1'b1;
    @(negedge clk);
    rd_done = 1'b0;
    model_rec(45, 7);
    chk({31'b0, stop_req}, 32'd1, "R10");
    chk({26'b0, stop_chan}, 32'd45, "R10");
    chk({31'b0, err_ready}, 32'd1, "R10");
    check_regs("R10");
    @(negedge clk);
    chk({31'b0, stop_req}, 32'd0, "R5");
    check_regs("R10");

    // R10: same code without pending read takes effect at once
    send(8, 7, 1'b0, 1'b0, 1'b0, 0, "R10");
    check_regs("R10");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule